// File: doc/BRIEF.md
# Commit Token Arbiter with Record and Replay

This block hands out a single commit token among a group of transactional cores. A core that has finished executing a transaction raises its request line and waits. The arbiter grants the token to exactly one requester. That core may then broadcast its commit, and it hands the token back by pulsing its done line. The arbiter then goes back to choosing among the cores still waiting.

The arbiter has two modes. In record mode it picks freely, using a rotating priority. For every grant it writes one byte to an outgoing log stream, and that byte names the winning core. In replay mode it reads bytes from an incoming log stream and grants only to the core named by the byte at the head of that stream. A run recorded earlier can therefore be reproduced in exactly the same commit order, whatever order the requests arrive in. A global halt input stops any new grant, so the whole system freezes at its next commit boundary for debugging.

A grant is shown as a registered one-hot vector. After every release there is one cycle with no grant, and the next decision is taken in that cycle.

Top module: `commit_token_arbiter`

## Requirements
- R1: At most one bit of `commit_grant` is high at any time. A granted core keeps the token until it pulses its own `commit_done` bit. A `commit_done` pulse from any other core has no effect on the grant.
- R2: A grant bit rises only for a core whose request was high in the cycle the decision was taken. In the cycle after the holder's done is sampled, `commit_grant` is all zero, and a new grant can appear one cycle after that.
- R3: Every grant produces exactly one log byte. The byte is presented on `log_out_data` with `log_out_valid` high from the first cycle the grant is visible. Bits [2:0] hold the core index and bits [7:3] are zero.
- R4: In record mode the winner is the first requesting core found by searching upward, with wraparound, from the core after the last grantee. After reset the last grantee is core 7, so core 0 has top priority.
- R5: In replay mode a grant goes only to the core named in bits [2:0] of `log_in_data`, and only while `log_in_valid` is high. `log_in_ready` is high in the same cycle the grant decision is taken, which consumes that entry. Other requesters wait, even if they asked earlier.
- R6: A grant decision is taken only in a cycle where the log output slot is empty or is being accepted (`log_out_ready` high). An entry that has not been accepted holds its value on `log_out_data`.
- R7: While `halt` is high, no new grant is decided. A core that already holds the token keeps it until its done pulse.
- R8: In replay mode, when no core holds the token and `log_in_valid` is low, `end_of_log` is high and no grant is issued.
- R9: Coming out of reset, `commit_grant` is zero, `log_out_valid` is low and `end_of_log` is low in record mode.
- R10: Replaying the log of a recorded run gives the same grant sequence as the recording, even with a different request arrival pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| replay_mode | input | 1 | 0 = record (free arbitration), 1 = replay (log-driven) |
| halt | input | 1 | Withhold any new grant |
| commit_req | input | 8 | Per-core token request |
| commit_done | input | 8 | Per-core token return pulse |
| commit_grant | output | 8 | One-hot token holder |
| log_out_valid | output | 1 | Outgoing log entry present |
| log_out_ready | input | 1 | Log sink accepts the entry |
| log_out_data | output | 8 | Outgoing log byte (core index) |
| log_in_valid | input | 1 | Incoming log entry present |
| log_in_ready | output | 1 | Incoming entry consumed this cycle |
| log_in_data | input | 8 | Incoming log byte (core index in low bits) |
| end_of_log | output | 1 | Replay mode, token free, no log entry available |

## Verification
The properties take three things for granted. Cores keep requesting until they are granted. In replay mode the head log entry stays stable while it is valid. Every entry that is replayed names a core that will eventually request, so a replay always makes progress. The properties also assume that the log sink does not hold its ready low forever. The bench's core models meet all of this: they raise a request only when they have a transaction pending, hold it until granted and pulse done only while holding the token. The replay feed comes straight from the bytes captured in the recorded run. The sink's ready toggles at random but keeps returning high.

// File: rtl/cta_pkg.sv
package cta_pkg;

    typedef enum logic [0:0] {
        TOK_FREE = 1'b0,
        TOK_HELD = 1'b1
    } tok_state_e;

    typedef enum logic [1:0] {
        PICK_NONE  = 2'd0,
        PICK_ROUND = 2'd1,
        PICK_LOG   = 2'd2
    } pick_src_e;

endpackage

// File: rtl/cta_rr_pick.sv
module cta_rr_pick #(
    parameter int N_REQ = 8,
    parameter int IDW   = 3
) (
    input  logic [N_REQ-1:0] req,
    input  logic [IDW-1:0]   last,
    output logic             found,
    output logic [IDW-1:0]   pick
);
    // Search upward from the core after the last grantee, wrapping around.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= N_REQ; k++) begin
            int pos;
            pos = (int'(last) + k) % N_REQ;
            if (!found && req[pos]) begin
                found = 1'b1;
                pick  = pos[IDW-1:0];
            end
        end
    end
endmodule

// File: rtl/cta_replay_match.sv
module cta_replay_match #(
    parameter int N_REQ = 8,
    parameter int IDW   = 3,
    parameter int LW    = 8
) (
    input  logic             head_valid,
    input  logic [LW-1:0]    head_data,
    input  logic [N_REQ-1:0] req,
    output logic [IDW-1:0]   target,
    output logic             hit
);
    always_comb begin
        target = head_data[IDW-1:0];
        hit    = head_valid && (int'(target) < N_REQ) && req[target];
    end
endmodule

// File: rtl/cta_log_slot.sv
module cta_log_slot #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] load_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [LW-1:0] out_data,
    output logic          free
);
    always_comb free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R6: an unaccepted entry stays put
    p_log_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/commit_token_arbiter.sv
module commit_token_arbiter
    import cta_pkg::*;
#(
    parameter int N_CORES = 8,
    parameter int LOG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               replay_mode,
    input  logic               halt,
    input  logic [N_CORES-1:0] commit_req,
    input  logic [N_CORES-1:0] commit_done,
    output logic [N_CORES-1:0] commit_grant,
    output logic               log_out_valid,
    input  logic               log_out_ready,
    output logic [LOG_W-1:0]   log_out_data,
    input  logic               log_in_valid,
    output logic               log_in_ready,
    input  logic [LOG_W-1:0]   log_in_data,
    output logic               end_of_log
);
    localparam int IDW = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam logic [N_CORES-1:0] ONE = {{(N_CORES-1){1'b0}}, 1'b1};

    tok_state_e state_q, state_nxt;
    logic [IDW-1:0] holder_q, last_q;
    logic [IDW-1:0] rr_pick, rp_target, win_id;
    logic           rr_found, rp_hit, log_free, take;
    pick_src_e      src;

    cta_rr_pick #(.N_REQ(N_CORES), .IDW(IDW)) u_rr (
        .req   (commit_req),
        .last  (last_q),
        .found (rr_found),
        .pick  (rr_pick)
    );

    cta_replay_match #(.N_REQ(N_CORES), .IDW(IDW), .LW(LOG_W)) u_match (
        .head_valid (log_in_valid),
        .head_data  (log_in_data),
        .req        (commit_req),
        .target     (rp_target),
        .hit        (rp_hit)
    );

    cta_log_slot #(.LW(LOG_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_data (LOG_W'(win_id)),
        .out_ready (log_out_ready),
        .out_valid (log_out_valid),
        .out_data  (log_out_data),
        .free      (log_free)
    );

    // Decision: which source may hand out the token this cycle
    always_comb begin
        src = PICK_NONE;
        if (state_q == TOK_FREE && !halt && log_free) begin
            if (replay_mode) src = rp_hit   ? PICK_LOG   : PICK_NONE;
            else             src = rr_found ? PICK_ROUND : PICK_NONE;
        end
        take   = (src != PICK_NONE);
        win_id = (src == PICK_LOG) ? rp_target : rr_pick;
    end

    // Next state: FREE --take--> HELD, HELD --holder done--> FREE
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            TOK_FREE: if (take)                  state_nxt = TOK_HELD;
            TOK_HELD: if (commit_done[holder_q]) state_nxt = TOK_FREE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TOK_FREE;
            holder_q <= '0;
            last_q   <= IDW'(N_CORES - 1);
        end else begin
            state_q <= state_nxt;
            if (take) begin
                holder_q <= win_id;
                last_q   <= win_id;
            end
        end
    end

    // Outputs
    always_comb begin
        commit_grant = '0;
        end_of_log   = 1'b0;
        unique case (state_q)
            TOK_FREE: end_of_log = replay_mode && !log_in_valid;
            TOK_HELD: commit_grant[holder_q] = 1'b1;
        endcase
        log_in_ready = (src == PICK_LOG);
    end

    // R1: single token
    p_one_token_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_grant));
    // R1: token kept until the holder itself returns it
    p_hold_until_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((|commit_grant) && !(|(commit_grant & commit_done)))
            |=> (commit_grant == $past(commit_grant)));
    // R2: a new grant needs a request in the deciding cycle
    p_grant_had_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|commit_grant) |-> (|(commit_grant & $past(commit_req))));
    // R2: idle cycle after release
    p_gap_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(commit_grant & commit_done)) |=> (commit_grant == '0));
    // R3: log entry names the new holder
    p_log_names_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|commit_grant) |-> (log_out_valid &&
            commit_grant == (ONE << log_out_data[IDW-1:0])));
    // R5: replay grants follow the log head
    p_replay_named_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|commit_grant) && $past(replay_mode)) |->
            ($past(log_in_valid) &&
             commit_grant == (ONE << $past(log_in_data[IDW-1:0]))));
    // R6: no grant while an earlier entry waits
    p_log_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|commit_grant) |-> $past(!log_out_valid || log_out_ready));
    // R7: halt blocks new grants
    p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !$rose(|commit_grant));
    // R8: empty replay log blocks new grants
    p_eol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_log |=> !$rose(|commit_grant));
endmodule

// File: tb/commit_token_arbiter_bench.sv
module commit_token_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 8;
    localparam int PER   = 5;
    localparam int TOT   = N * PER;
    localparam int WD    = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic replay_mode = 1'b0;
    logic halt = 1'b0;
    logic auto_en = 1'b0;
    logic [N-1:0] m_req = '0, m_done = '0, a_req = '0, a_done = '0;
    logic m_lready = 1'b1, a_lready = 1'b1;
    logic m_lin_valid = 1'b0;
    logic [7:0] m_lin_data = '0;

    logic [N-1:0] commit_req, commit_done, commit_grant;
    logic log_out_valid, log_out_ready, log_in_valid, log_in_ready, end_of_log;
    logic [7:0] log_out_data, log_in_data;

    logic [7:0] rec_log [0:255];
    int rec_n = 0;
    int rd_ptr = 0;
    logic [7:0] cap_log [0:255];
    int cap_n = 0;
    int gseq [0:255];
    int g_n = 0;
    logic [N-1:0] prev_g = '0;
    int arm_cnt = 0, arm_seen = 0;
    int left [N], dly [N], hold [N];
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign commit_req    = auto_en ? a_req : m_req;
    assign commit_done   = auto_en ? a_done : m_done;
    assign log_out_ready = auto_en ? a_lready : m_lready;
    assign log_in_valid  = (auto_en && replay_mode) ? (rd_ptr < rec_n) : m_lin_valid;
    assign log_in_data   = (auto_en && replay_mode) ? rec_log[rd_ptr[7:0]] : m_lin_data;

    commit_token_arbiter u_commit_token_arbiter (
        .clk, .rst_n, .replay_mode, .halt, .commit_req, .commit_done,
        .commit_grant, .log_out_valid, .log_out_ready, .log_out_data,
        .log_in_valid, .log_in_ready, .log_in_data, .end_of_log
    );

    function automatic int gid(input logic [N-1:0] g);
        int r;
        r = -1;
        for (int i = 0; i < N; i++) if (g[i]) r = (r == -1) ? i : -2;
        return r;
    endfunction

    // Observers: log sink capture, grant sequence, replay feed
    always @(posedge clk) begin
        if (rst_n && log_out_valid && log_out_ready && cap_n < 256) begin
            cap_log[cap_n[7:0]] <= log_out_data;
            cap_n <= cap_n + 1;
        end
        if (rst_n && commit_grant != '0 && prev_g == '0 && g_n < 256) begin
            gseq[g_n[7:0]] <= gid(commit_grant);
            g_n <= g_n + 1;
        end
        prev_g <= commit_grant;
        if (auto_en && replay_mode && log_in_valid && log_in_ready)
            rd_ptr <= rd_ptr + 1;
    end

    // Core models for the random runs
    always @(negedge clk) begin
        if (arm_cnt != arm_seen) begin
            arm_seen = arm_cnt;
            for (int i = 0; i < N; i++) begin
                left[i] = PER; dly[i] = $urandom_range(0, 9); hold[i] = 0;
            end
            a_req = '0; a_done = '0;
        end else if (auto_en) begin
            a_lready = ($urandom_range(0, 3) != 0);
            for (int i = 0; i < N; i++) begin
                if (a_done[i]) begin
                    a_done[i] = 1'b0;
                end else if (commit_grant[i]) begin
                    if (hold[i] == 0) begin
                        a_done[i] = 1'b1; a_req[i] = 1'b0;
                        left[i] = left[i] - 1; dly[i] = $urandom_range(0, 7);
                    end else hold[i] = hold[i] - 1;
                end else if (!a_req[i] && left[i] > 0) begin
                    if (dly[i] == 0) begin
                        a_req[i] = 1'b1; hold[i] = $urandom_range(0, 2);
                    end else dly[i] = dly[i] - 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic release_core(input int c);
        m_done[c] = 1'b1; m_req[c] = 1'b0;
        @(negedge clk);
        m_done = '0;
        chk("R2", "grant low after release", int'(commit_grant), 0);
    endtask

    task automatic expect_grant(input int c, input string tag);
        @(negedge clk);
        chk(tag, "grantee", gid(commit_grant), c);
        chk("R3", "log valid with grant", int'(log_out_valid), 1);
        chk("R3", "log byte", int'(log_out_data), c);
    endtask

    task automatic t_reset;
        chk("R9", "grant at reset", int'(commit_grant), 0);
        chk("R9", "log valid at reset", int'(log_out_valid), 0);
        chk("R9", "end_of_log at reset", int'(end_of_log), 0);
    endtask

    task automatic t_round_robin;
        m_req = '1;
        for (int k = 0; k < N; k++) begin
            expect_grant(k, "R4");
            release_core(k);
        end
        m_req = '0;
    endtask

    task automatic t_wrap;
        m_req = 8'b0100_1000;
        expect_grant(3, "R4"); release_core(3);
        expect_grant(6, "R4"); release_core(6);
        m_req = 8'b0010_0010;
        expect_grant(1, "R4"); release_core(1);
        expect_grant(5, "R4"); release_core(5);
    endtask

    task automatic t_foreign_done;
        m_req[4] = 1'b1;
        expect_grant(4, "R1");
        m_done[2] = 1'b1;
        @(negedge clk);
        m_done = '0;
        chk("R1", "holder after foreign done", gid(commit_grant), 4);
        repeat (2) @(negedge clk);
        chk("R1", "holder still kept", gid(commit_grant), 4);
        release_core(4);
    endtask

    task automatic t_halt;
        halt = 1'b1; m_req[5] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7", "no grant while halted", int'(commit_grant), 0);
        halt = 1'b0;
        expect_grant(5, "R7");
        halt = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7", "holder keeps token under halt", gid(commit_grant), 5);
        release_core(5);
        halt = 1'b0;
    endtask

    task automatic t_backpressure;
        m_lready = 1'b0; m_req[1] = 1'b1;
        expect_grant(1, "R6");
        release_core(1);
        m_req[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6", "no grant while log full", int'(commit_grant), 0);
        chk("R6", "old entry still valid", int'(log_out_valid), 1);
        chk("R6", "old entry held", int'(log_out_data), 1);
        m_lready = 1'b1;
        expect_grant(2, "R6");
        release_core(2);
    endtask

    task automatic t_replay_manual;
        replay_mode = 1'b1; m_lin_valid = 1'b0;
        @(negedge clk);
        chk("R8", "end_of_log when empty", int'(end_of_log), 1);
        m_req = 8'b0000_1100;
        repeat (2) @(negedge clk);
        chk("R8", "no grant with empty log", int'(commit_grant), 0);
        m_lin_valid = 1'b1; m_lin_data = 8'd6;
        @(negedge clk);
        chk("R5", "others wait for named core", int'(commit_grant), 0);
        chk("R8", "end_of_log low with entry", int'(end_of_log), 0);
        m_req[6] = 1'b1;
        #1;
        chk("R5", "entry consumed on decision", int'(log_in_ready), 1);
        expect_grant(6, "R5");
        m_lin_data = 8'd3;
        release_core(6);
        expect_grant(3, "R5");
        m_lin_valid = 1'b0;
        release_core(3);
        @(negedge clk);
        chk("R8", "no grant after log runs out", int'(commit_grant), 0);
        chk("R8", "end_of_log raised again", int'(end_of_log), 1);
        m_req = '0;
        @(negedge clk);
        replay_mode = 1'b0;
    endtask

    task automatic wait_run(input int gbase, input int cbase);
        while (!((g_n - gbase) == TOT && (cap_n - cbase) == TOT &&
                 commit_grant == '0 && !log_out_valid))
            @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_record_replay;
        int gb, cb, gb2, cb2, bad, lbad;
        replay_mode = 1'b0;
        gb = g_n; cb = cap_n;
        arm_cnt++; auto_en = 1'b1;
        wait_run(gb, cb);
        auto_en = 1'b0;
        chk("R3", "one log byte per grant", cap_n - cb, g_n - gb);
        lbad = 0;
        for (int i = 0; i < TOT; i++) begin
            if (int'(cap_log[(cb + i) % 256]) != gseq[(gb + i) % 256]) lbad++;
            rec_log[i] = cap_log[(cb + i) % 256];
        end
        chk("R3", "recorded bytes match grants", lbad, 0);
        rec_n = TOT;
        replay_mode = 1'b1;
        gb2 = g_n; cb2 = cap_n;
        arm_cnt++;
        @(negedge clk);
        auto_en = 1'b1;
        wait_run(gb2, cb2);
        chk("R10", "log fully consumed", rd_ptr, rec_n);
        chk("R8", "end_of_log after replay", int'(end_of_log), 1);
        auto_en = 1'b0;
        bad = 0;
        for (int i = 0; i < TOT; i++)
            if (gseq[(gb2 + i) % 256] != gseq[(gb + i) % 256]) bad++;
        chk("R10", "replayed order mismatches", bad, 0);
        lbad = 0;
        for (int i = 0; i < TOT; i++)
            if (cap_log[(cb2 + i) % 256] != rec_log[i]) lbad++;
        chk("R3", "replay log echo mismatches", lbad, 0);
        replay_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_round_robin();
        t_wrap();
        t_foreign_done();
        t_halt();
        t_backpressure();
        t_replay_manual();
        t_record_replay();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule